// File: doc/BRIEF.md
# Floating-Point Multiply Special-Case Dispatcher

This block sits in front of the mantissa multiplier of a floating-point unit. Each of its two operands arrives already classified as zero, finite number, infinity or NaN, with a sign bit and a flag that marks a NaN as signaling. The block ranks the two operands by class and places the higher-ranked one on the right. It then runs a fixed-priority test over that ordered pair. The test yields one of four outcomes: forward one of the original operands, produce the default NaN, hand the pair to the multiply datapath, or forward a zero. Along with the outcome it gives the result sign and raises at most one invalid-operation flag.

The decision is combinational. It is captured in one output register stage whose clock enable is the input valid strobe, so a new decision is visible one cycle after it is presented. The result selector names the original operand (A or B), which spares the downstream mux any knowledge of the internal swap. When the default NaN is selected, the block also drives its fraction pattern, which is fixed by a parameter.

Top module: `fpmd_mul_dispatch`

## Requirements
- R1: After reset, out_valid, out_sel, out_sign, out_exc and out_dnan_frac are all zero. A decision taken with in_valid high in one cycle appears with out_valid high in the next cycle.
- R2: Ranking keys are computed for each operand, in increasing order: zero (class code 0), number (1), infinity (2), quiet NaN (3), signaling NaN (class 3 with the snan flag set). The snan flag is ignored for other classes. The operand with the larger key becomes the right operand. On equal keys, A stays left and B stays right.
- R3: If the right operand is a NaN, that operand is forwarded, with sign = sign A XOR sign B. The result is out_exc = 2'b01 (bit 0 is the NaN invalid flag).
- R4: If the right operand is infinity and the left operand is zero, out_sel = 2 (default NaN) and out_sign = 0. Also out_exc = 2'b10 (bit 1 is the infinity-times-zero flag) and out_dnan_frac = DNAN_FRAC.
- R5: If the right operand is infinity and the left operand is not zero, the infinity operand is forwarded with sign = sign A XOR sign B, and out_exc = 0.
- R6: If the left operand is zero and the right operand is zero or a number, the left (zero) operand is forwarded with sign = sign A XOR sign B, and out_exc = 0.
- R7: If both operands are numbers, out_sel = 3 (multiply datapath), out_sign = sign A XOR sign B, and out_exc = 0.
- R8: Selector codes are 0 for operand A, 1 for operand B, 2 for the default NaN and 3 for the datapath. out_dnan_frac is zero whenever out_sel is not 2.
- R9: While in_valid is low, out_valid is low and out_sel, out_sign, out_exc and out_dnan_frac keep their last values, whatever the operand inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands valid; enables the output register |
| a_cls | input | 2 | Class of operand A |
| a_sign | input | 1 | Sign of operand A |
| a_snan | input | 1 | Operand A is a signaling NaN (used only for class 3) |
| b_cls | input | 2 | Class of operand B |
| b_sign | input | 1 | Sign of operand B |
| b_snan | input | 1 | Operand B is a signaling NaN (used only for class 3) |
| out_valid | output | 1 | Registered decision valid |
| out_sel | output | 2 | Result source selector |
| out_sign | output | 1 | Result sign |
| out_exc | output | 2 | Invalid-operation flags |
| out_dnan_frac | output | FRAC_W | Default NaN fraction when selected, else zero |

## Verification
The assertions check on every cycle that at most one exception bit is set and that the default NaN is always positive with its fixed fraction and the infinity-times-zero flag. They also check that every other outcome carries the XOR of the sampled signs, that the datapath is only chosen for two numbers, that a NaN input always raises the NaN flag, and that the outputs hold while no operands arrive. Some behaviours need the bench's exhaustive sweep over every class pair, sign pair and signaling combination in both orders. These are which operand is forwarded when ranks tie or differ, the preference for the signaling NaN, and the exact priority between a NaN and an infinity-by-zero pair.

// File: rtl/fpmd_pkg.sv
package fpmd_pkg;

  // operand class codes; numeric order is the ranking order
  localparam logic [1:0] CLS_ZERO = 2'd0;
  localparam logic [1:0] CLS_NUM  = 2'd1;
  localparam logic [1:0] CLS_INF  = 2'd2;
  localparam logic [1:0] CLS_NAN  = 2'd3;

  // result selector codes
  localparam logic [1:0] SEL_A    = 2'd0;
  localparam logic [1:0] SEL_B    = 2'd1;
  localparam logic [1:0] SEL_DNAN = 2'd2;
  localparam logic [1:0] SEL_MUL  = 2'd3;

  localparam int EXC_W        = 2;
  localparam int EXC_NAN_BIT  = 0;
  localparam int EXC_IMZ_BIT  = 1;
  localparam int KEY_W        = 3;

  typedef struct packed {
    logic [1:0] cls;
    logic       sign;
    logic       snan;
  } opnd_t;

  // rank key: class, then signaling flag as a tie breaker among NaNs
  function automatic logic [KEY_W-1:0] rank_key(input opnd_t o);
    return {o.cls, (o.cls == CLS_NAN) & o.snan};
  endfunction

endpackage

// File: rtl/fpmd_rst_sync.sv
module fpmd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  localparam int SW = (STAGES < 2) ? 2 : STAGES;

  logic [SW-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) chain_q <= '0;
    else           chain_q <= {chain_q[SW-2:0], 1'b1};
  end

  assign rst_n_out = chain_q[SW-1];
endmodule

// File: rtl/fpmd_order.sv
module fpmd_order
  import fpmd_pkg::*;
(
  input  opnd_t op_a,
  input  opnd_t op_b,
  output opnd_t op_left,
  output opnd_t op_right,
  output logic  swapped
);
  logic [KEY_W-1:0] key_a;
  logic [KEY_W-1:0] key_b;

  always_comb begin
    key_a   = rank_key(op_a);
    key_b   = rank_key(op_b);
    swapped = (key_a > key_b);
    if (swapped) begin
      op_left  = op_b;
      op_right = op_a;
    end else begin
      op_left  = op_a;
      op_right = op_b;
    end
  end
endmodule

// File: rtl/fpmd_decide.sv
module fpmd_decide
  import fpmd_pkg::*;
(
  input  opnd_t            op_left,
  input  opnd_t            op_right,
  input  logic             swapped,
  output logic [1:0]       sel,
  output logic             sign,
  output logic [EXC_W-1:0] exc
);
  logic [1:0] sel_right;
  logic [1:0] sel_left;
  logic       sign_x;

  always_comb begin
    sel_right = swapped ? SEL_A : SEL_B;
    sel_left  = swapped ? SEL_B : SEL_A;
    sign_x    = op_left.sign ^ op_right.sign;
    exc       = '0;
    sel       = SEL_MUL;
    sign      = sign_x;
    if (op_right.cls == CLS_NAN) begin
      sel              = sel_right;
      exc[EXC_NAN_BIT] = 1'b1;
    end else if (op_right.cls == CLS_INF) begin
      if (op_left.cls == CLS_ZERO) begin
        sel              = SEL_DNAN;
        sign             = 1'b0;
        exc[EXC_IMZ_BIT] = 1'b1;
      end else begin
        sel = sel_right;
      end
    end else if (op_left.cls == CLS_ZERO) begin
      sel = sel_left;
    end
  end
endmodule

// File: rtl/fpmd_mul_dispatch.sv
module fpmd_mul_dispatch
  import fpmd_pkg::*;
#(
  parameter int              FRAC_W    = 23,
  parameter logic [FRAC_W-1:0] DNAN_FRAC = {1'b1, {(FRAC_W-1){1'b0}}},
  parameter int              SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [1:0]        a_cls,
  input  logic              a_sign,
  input  logic              a_snan,
  input  logic [1:0]        b_cls,
  input  logic              b_sign,
  input  logic              b_snan,
  output logic              out_valid,
  output logic [1:0]        out_sel,
  output logic              out_sign,
  output logic [1:0]        out_exc,
  output logic [FRAC_W-1:0] out_dnan_frac
);
  logic       rst_n_sync;
  opnd_t      op_a, op_b, op_l, op_r;
  logic       swapped;
  logic [1:0] dec_sel;
  logic       dec_sign;
  logic [EXC_W-1:0] dec_exc;

  logic       valid_q, valid_d;
  logic [1:0] sel_q, sel_d;
  logic       sign_q, sign_d;
  logic [EXC_W-1:0] exc_q, exc_d;

  fpmd_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_n_sync)
  );

  assign op_a = '{cls: a_cls, sign: a_sign, snan: a_snan};
  assign op_b = '{cls: b_cls, sign: b_sign, snan: b_snan};

  fpmd_order u_order (
    .op_a(op_a), .op_b(op_b), .op_left(op_l), .op_right(op_r), .swapped(swapped)
  );

  fpmd_decide u_decide (
    .op_left(op_l), .op_right(op_r), .swapped(swapped),
    .sel(dec_sel), .sign(dec_sign), .exc(dec_exc)
  );

  // next state: capture only when operands are presented
  always_comb begin
    valid_d = in_valid;
    sel_d   = sel_q;
    sign_d  = sign_q;
    exc_d   = exc_q;
    if (in_valid) begin
      sel_d  = dec_sel;
      sign_d = dec_sign;
      exc_d  = dec_exc;
    end
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      valid_q <= 1'b0;
      sel_q   <= SEL_A;
      sign_q  <= 1'b0;
      exc_q   <= '0;
    end else begin
      valid_q <= valid_d;
      sel_q   <= sel_d;
      sign_q  <= sign_d;
      exc_q   <= exc_d;
    end
  end

  assign out_valid     = valid_q;
  assign out_sel       = sel_q;
  assign out_sign      = sign_q;
  assign out_exc       = exc_q;
  assign out_dnan_frac = (sel_q == SEL_DNAN) ? DNAN_FRAC : '0;
endmodule

// File: rtl/fpmd_checker.sv
module fpmd_checker
  import fpmd_pkg::*;
#(
  parameter int                FRAC_W    = 23,
  parameter logic [FRAC_W-1:0] DNAN_FRAC = {1'b1, {(FRAC_W-1){1'b0}}}
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [1:0]        a_cls,
  input logic              a_sign,
  input logic [1:0]        b_cls,
  input logic              b_sign,
  input logic              out_valid,
  input logic [1:0]        out_sel,
  input logic              out_sign,
  input logic [1:0]        out_exc,
  input logic [FRAC_W-1:0] out_dnan_frac
);
  // R3 R4
  exc_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $onehot0(out_exc));

  // R4
  dnan_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_sel == SEL_DNAN) |->
      (!out_sign && out_exc == 2'b10 && out_dnan_frac == DNAN_FRAC));

  // R8
  dnan_frac_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_sel != SEL_DNAN) |-> (out_dnan_frac == '0));

  // R3
  nan_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(a_cls == CLS_NAN || b_cls == CLS_NAN)) |->
      (out_exc == 2'b01));

  // R5 R6 R7
  sign_xor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_sel != SEL_DNAN) |-> (out_sign == $past(a_sign ^ b_sign)));

  // R7
  mul_operands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_sel == SEL_MUL) |->
      ($past(a_cls == CLS_NUM && b_cls == CLS_NUM) && out_exc == 2'b00));

  // R2
  lower_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_sel == SEL_B && $past(a_cls > b_cls)) |->
      $past(b_cls == CLS_ZERO && a_cls == CLS_NUM));

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!in_valid) |->
      (!out_valid && $stable(out_sel) && $stable(out_sign) && $stable(out_exc)));
endmodule

bind fpmd_mul_dispatch fpmd_checker #(.FRAC_W(FRAC_W), .DNAN_FRAC(DNAN_FRAC)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
  .a_cls(a_cls), .a_sign(a_sign), .b_cls(b_cls), .b_sign(b_sign),
  .out_valid(out_valid), .out_sel(out_sel), .out_sign(out_sign),
  .out_exc(out_exc), .out_dnan_frac(out_dnan_frac)
);

// File: tb/sim_fpmd_mul_dispatch.sv
`timescale 1ns/1ps
module sim_fpmd_mul_dispatch;
  localparam int              FW    = 10;
  localparam logic [FW-1:0]   DFRAC = 10'h25A;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [1:0]    a_cls = 2'd0, b_cls = 2'd0;
  logic          a_sign = 1'b0, b_sign = 1'b0, a_snan = 1'b0, b_snan = 1'b0;
  logic          out_valid, out_sign;
  logic [1:0]    out_sel, out_exc;
  logic [FW-1:0] out_dnan_frac;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  fpmd_mul_dispatch #(.FRAC_W(FW), .DNAN_FRAC(DFRAC)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .a_cls(a_cls), .a_sign(a_sign), .a_snan(a_snan),
    .b_cls(b_cls), .b_sign(b_sign), .b_snan(b_snan),
    .out_valid(out_valid), .out_sel(out_sel), .out_sign(out_sign),
    .out_exc(out_exc), .out_dnan_frac(out_dnan_frac)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int e_sel, e_sign, e_exc, e_frac;
    string tag;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "valid", out_valid, 0);
    chk("R1", "sel", out_sel, 0);
    chk("R1", "sign", out_sign, 0);
    chk("R1", "exc", out_exc, 0);
    chk("R1", "frac", out_dnan_frac, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "valid idle", out_valid, 0);

    for (int ac = 0; ac < 4; ac++)
      for (int bc = 0; bc < 4; bc++)
        for (int v = 0; v < 16; v++) begin
          int ka, kb, lc, rc;
          bit sw, xs;
          a_cls = 2'(ac); b_cls = 2'(bc);
          a_sign = v[0]; b_sign = v[1]; a_snan = v[2]; b_snan = v[3];
          in_valid = 1'b1;
          // expected, per requirements
          ka = ac * 2 + ((ac == 3 && v[2]) ? 1 : 0);
          kb = bc * 2 + ((bc == 3 && v[3]) ? 1 : 0);
          sw = (ka > kb);
          rc = sw ? ac : bc;
          lc = sw ? bc : ac;
          xs = v[0] ^ v[1];
          e_frac = 0;
          if (rc == 3) begin
            tag = "R3"; e_sel = sw ? 0 : 1; e_sign = xs; e_exc = 1;
          end else if (rc == 2 && lc == 0) begin
            tag = "R4"; e_sel = 2; e_sign = 0; e_exc = 2; e_frac = DFRAC;
          end else if (rc == 2) begin
            tag = "R5"; e_sel = sw ? 0 : 1; e_sign = xs; e_exc = 0;
          end else if (lc == 0) begin
            tag = "R6"; e_sel = sw ? 1 : 0; e_sign = xs; e_exc = 0;
          end else begin
            tag = "R7"; e_sel = 3; e_sign = xs; e_exc = 0;
          end
          @(negedge clk);
          chk("R1", "valid latency", out_valid, 1);
          // R2 governs which operand is forwarded; R8 governs the codes
          chk(sw ? {tag, "/R2"} : tag, "sel", out_sel, e_sel);
          chk(tag, "sign", out_sign, e_sign);
          chk(tag, "exc", out_exc, e_exc);
          chk("R8", "frac", out_dnan_frac, e_frac);
        end

    // R9 hold: last result was NaN,NaN with both snan -> right is B
    in_valid = 1'b0;
    a_cls = 2'd1; b_cls = 2'd1; a_sign = 1'b0; b_sign = 1'b1;
    @(negedge clk);
    chk("R9", "valid low", out_valid, 0);
    chk("R9", "sel held", out_sel, 1);
    chk("R9", "sign held", out_sign, 0);
    chk("R9", "exc held", out_exc, 1);
    a_cls = 2'd2; b_cls = 2'd0;
    @(negedge clk);
    chk("R9", "sel held 2", out_sel, 1);
    chk("R9", "frac held", out_dnan_frac, 0);

    // R4 directly, then R9 hold of the default NaN
    in_valid = 1'b1; a_cls = 2'd0; b_cls = 2'd2; a_sign = 1'b1; b_sign = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; a_cls = 2'd1; b_cls = 2'd1;
    chk("R4", "dnan sel", out_sel, 2);
    chk("R4", "dnan frac", out_dnan_frac, DFRAC);
    @(negedge clk);
    chk("R9", "dnan held", out_sel, 2);
    chk("R9", "dnan frac held", out_dnan_frac, DFRAC);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule